// File: doc/BRIEF.md
# Transmit-Start / Jabber Interrupt Status Slice

This block is a small register slice of a network controller. It records two hardware events, the start of a frame transmission and a jabber fault reported by the twisted-pair transceiver logic, and gives each one a sticky status bit and a mask bit. Software clears a status bit by writing a one to it. The block combines the status bits that are not masked with a global interrupt enable and drives a registered interrupt request.

The slice also holds a second register that is mostly read-only. It keeps the encoded transmit and receive ring-length codes that the initialization sequence delivers through a load strobe. Software can see these codes only while the controller is stopped. Resets and STOP clear the status bits but leave the ring codes alone. The mask bits survive STOP and come out of reset as one. A legacy software-style flag hides the jabber function.

Software reaches the slice through a simple register port. Reads have one cycle of latency. The status/mask word sits at address 0 and the ring-length word at address 1.

Top module: `evt_irq_regs`

## Requirements
- R1: After hard reset (hardRstN low) or soft reset (softRst high), both status bits read 0, both mask bits read 1, and irqReq is 0.
- R2: A txStartEvt pulse sets the transmit-start status bit, which is bit 3 of the word at address 0. The bit reads as set from the next clock edge onward.
- R3: A jabberEvt pulse sets the jabber status bit (bit 1 of address 0) only while tpMode is 1 and legacyStyle is 0. At any other time the pulse has no effect.
- R4: A write to address 0 clears each status bit (bits 3 and 1) whose write-data bit is 1. A write-data bit of 0 leaves the matching status bit unchanged.
- R5: When a set event and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R6: While stopCtl is 1, both status bits are held at 0 and set events are ignored. The mask bits keep their values.
- R7: The mask bits are read/write: bit 2 masks transmit-start and bit 0 masks jabber. A write to address 0 loads both mask bits from regWdata[2] and regWdata[0].
- R8: irqReq is a registered level. It is 1 in the cycle after irqEnable is 1 and at least one status bit is set while its mask is 0. Otherwise it is 0.
- R9: While legacyStyle is 1, the jabber status bit and the jabber mask bit both read as 0, and jabber cannot raise irqReq. The stored mask value reappears once legacyStyle returns to 0.
- R10: A read of address 1 while stopCtl is 1 returns the transmit code in bits 15:12 and the receive code in bits 11:8, with all other bits 0. The same read while stopCtl is 0 returns all zeros.
- R11: The ring codes change only on ringLoad. Writes to address 1, hard reset, soft reset and STOP leave them unchanged.
- R12: regRdata loads the selected word on the clock edge where regRd is 1 and holds it otherwise. At address 0, bits 15:4 read 0. Any address other than 0 or 1 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset, active high |
| stopCtl | input | 1 | STOP control level |
| tpMode | input | 1 | 10BASE-T mode flag |
| legacyStyle | input | 1 | Legacy software-style compatibility flag |
| irqEnable | input | 1 | Global interrupt enable |
| txStartEvt | input | 1 | Frame transmission start pulse from the MAC |
| jabberEvt | input | 1 | Jabber indication from the transceiver logic |
| ringLoad | input | 1 | Load strobe from the initialization sequence |
| ringTxCode | input | 4 | Encoded transmit ring length to load |
| ringRxCode | input | 4 | Encoded receive ring length to load |
| regAddr | input | 2 | Register address |
| regWdata | input | 4 | Write data (status/mask bits) |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regRdata | output | 16 | Registered read data |
| irqReq | output | 1 | Registered interrupt request |

## Verification
An event or a write lands on the first clock edge after it is driven. A read issued in the following cycle therefore shows it in regRdata one edge later. irqReq is derived from the status registers, so it also follows the event by two edges, and it lines up with that same read. The bench drives every input on the falling edge and holds it for exactly one rising edge. It samples regRdata and irqReq on the next falling edge, so each check lands in the cycle where the result is due. The main sweep covers every combination of enable, both masks and both events, and a second sweep covers every pair of ring codes.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W   = 16;
  localparam int STAT_W   = 4;
  localparam int CODE_W   = 4;
  localparam int BIT_TXST = 3;
  localparam int BIT_TXMK = 2;
  localparam int BIT_JBST = 1;
  localparam int BIT_JBMK = 0;
  localparam int TX_LSB   = 12;
  localparam int RX_LSB   = 8;

  typedef struct packed {
    logic clrStatus;   // soft reset or STOP: force status low
    logic rstMask;     // soft reset: masks to one
    logic wrMask;      // load masks from write data
    logic clrTx;       // write-one clear, transmit start
    logic clrJab;      // write-one clear, jabber
    logic setTx;       // hardware set, transmit start
    logic setJab;      // hardware set, jabber (qualified)
    logic jabHide;     // legacy style hides jabber
    logic rdStat;      // capture status word
    logic rdRing;      // capture ring word
    logic rdOther;     // capture zero
    logic ringVisible; // ring codes visible on read
    logic ringLoad;    // load ring codes
  } ctrlStrobes_t;
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_STAT = 0,
  parameter int ADDR_RING = 1
) (
  input  logic              softRst,
  input  logic              stopCtl,
  input  logic              tpMode,
  input  logic              legacyStyle,
  input  logic              txStartEvt,
  input  logic              jabberEvt,
  input  logic              ringLoad,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_RING = ADDR_W'(ADDR_RING);

  logic hitStat;
  logic hitRing;
  logic wrStat;

  always_comb begin
    hitStat = (regAddr == A_STAT);
    hitRing = (regAddr == A_RING);
    wrStat  = regWr && hitStat;

    strobes             = '0;
    strobes.clrStatus   = softRst || stopCtl;
    strobes.rstMask     = softRst;
    strobes.wrMask      = wrStat;
    strobes.clrTx       = wrStat && regWdata[BIT_TXST];
    strobes.clrJab      = wrStat && regWdata[BIT_JBST];
    strobes.setTx       = txStartEvt;
    strobes.setJab      = jabberEvt && tpMode && !legacyStyle;
    strobes.jabHide     = legacyStyle;
    strobes.rdStat      = regRd && hitStat;
    strobes.rdRing      = regRd && hitRing;
    strobes.rdOther     = regRd && !hitStat && !hitRing;
    strobes.ringVisible = stopCtl;
    strobes.ringLoad    = ringLoad;
  end
endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              hardRstN,
  input  ctrlStrobes_t      strobes,
  input  logic              irqEnable,
  input  logic [STAT_W-1:0] regWdata,
  input  logic [CODE_W-1:0] ringTxCode,
  input  logic [CODE_W-1:0] ringRxCode,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqReq,
  output logic              txSt,
  output logic              jabSt,
  output logic              txMask,
  output logic              jabMask
);
  logic [CODE_W-1:0] txCode;
  logic [CODE_W-1:0] rxCode;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] ringWord;
  logic              jabLive;
  logic              irqNext;

  // Status bits: clear forced by reset/STOP, then set beats write-one clear.
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      txSt  <= 1'b0;
      jabSt <= 1'b0;
    end else if (strobes.clrStatus) begin
      txSt  <= 1'b0;
      jabSt <= 1'b0;
    end else begin
      if (strobes.setTx)       txSt <= 1'b1;
      else if (strobes.clrTx)  txSt <= 1'b0;
      if (strobes.setJab)      jabSt <= 1'b1;
      else if (strobes.clrJab) jabSt <= 1'b0;
    end
  end

  // Mask bits: reset to one, untouched by STOP.
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      txMask  <= 1'b1;
      jabMask <= 1'b1;
    end else if (strobes.rstMask) begin
      txMask  <= 1'b1;
      jabMask <= 1'b1;
    end else if (strobes.wrMask) begin
      txMask  <= regWdata[BIT_TXMK];
      jabMask <= regWdata[BIT_JBMK];
    end
  end

  // Ring codes keep their value through every reset.
  always_ff @(posedge clk) begin
    if (strobes.ringLoad) begin
      txCode <= ringTxCode;
      rxCode <= ringRxCode;
    end
  end

  always_comb begin
    jabLive  = jabSt && !strobes.jabHide;
    statWord = '0;
    statWord[BIT_TXST] = txSt;
    statWord[BIT_TXMK] = txMask;
    statWord[BIT_JBST] = jabLive;
    statWord[BIT_JBMK] = jabMask && !strobes.jabHide;
    ringWord = '0;
    if (strobes.ringVisible) begin
      ringWord[TX_LSB +: CODE_W] = txCode;
      ringWord[RX_LSB +: CODE_W] = rxCode;
    end
    irqNext = irqEnable && ((txSt && !txMask) || (jabLive && !jabMask));
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      regRdata <= '0;
    end else if (strobes.rdStat) begin
      regRdata <= statWord;
    end else if (strobes.rdRing) begin
      regRdata <= ringWord;
    end else if (strobes.rdOther) begin
      regRdata <= '0;
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)            irqReq <= 1'b0;
    else if (strobes.rstMask) irqReq <= 1'b0;
    else                      irqReq <= irqNext;
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_STAT = 0,
  parameter int ADDR_RING = 1
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              stopCtl,
  input  logic              tpMode,
  input  logic              legacyStyle,
  input  logic              irqEnable,
  input  logic              txStartEvt,
  input  logic              jabberEvt,
  input  logic              ringLoad,
  input  logic [CODE_W-1:0] ringTxCode,
  input  logic [CODE_W-1:0] ringRxCode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqReq
);
  ctrlStrobes_t strobes;
  logic txSt;
  logic jabSt;
  logic txMask;
  logic jabMask;

  evt_irq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_STAT(ADDR_STAT), .ADDR_RING(ADDR_RING)
  ) u_ctrl (
    .softRst(softRst), .stopCtl(stopCtl), .tpMode(tpMode),
    .legacyStyle(legacyStyle), .txStartEvt(txStartEvt),
    .jabberEvt(jabberEvt), .ringLoad(ringLoad), .regAddr(regAddr),
    .regWdata(regWdata), .regWr(regWr), .regRd(regRd), .strobes(strobes)
  );

  evt_irq_dp u_dp (
    .clk(clk), .hardRstN(hardRstN), .strobes(strobes),
    .irqEnable(irqEnable), .regWdata(regWdata),
    .ringTxCode(ringTxCode), .ringRxCode(ringRxCode),
    .regRdata(regRdata), .irqReq(irqReq),
    .txSt(txSt), .jabSt(jabSt), .txMask(txMask), .jabMask(jabMask)
  );
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk #(
  parameter int ADDR_W    = 2,
  parameter int ADDR_RING = 1,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              hardRstN,
  input logic              softRst,
  input logic              stopCtl,
  input logic              tpMode,
  input logic              legacyStyle,
  input logic              irqEnable,
  input logic              txStartEvt,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqReq,
  input logic              txSt,
  input logic              jabSt,
  input logic              txMask,
  input logic              jabMask
);
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!hardRstN)
    stopCtl |=> (!txSt && !jabSt));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!hardRstN)
    (stopCtl && !softRst && !regWr) |=> ($stable(txMask) && $stable(jabMask)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!hardRstN)
    (txStartEvt && !stopCtl && !softRst) |=> txSt);

  p_jab_blocked_r3: assert property (@(posedge clk) disable iff (!hardRstN)
    (!jabSt && (!tpMode || legacyStyle)) |=> !jabSt);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!hardRstN)
    !irqEnable |=> !irqReq);

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!hardRstN)
    (irqEnable && txSt && !txMask && !softRst) |=> irqReq);

  p_ring_hidden_r10: assert property (@(posedge clk) disable iff (!hardRstN)
    (regRd && (regAddr == ADDR_W'(ADDR_RING)) && !stopCtl) |=> (regRdata == '0));

  p_soft_masks_r1: assert property (@(posedge clk) disable iff (!hardRstN)
    softRst |=> (txMask && jabMask && !irqReq));
endmodule

bind evt_irq_regs evt_irq_regs_chk #(
  .ADDR_W(ADDR_W), .ADDR_RING(ADDR_RING), .DATA_W(evt_irq_pkg::DATA_W)
) u_chk (
  .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stopCtl(stopCtl),
  .tpMode(tpMode), .legacyStyle(legacyStyle), .irqEnable(irqEnable),
  .txStartEvt(txStartEvt), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .regRdata(regRdata), .irqReq(irqReq), .txSt(txSt), .jabSt(jabSt),
  .txMask(txMask), .jabMask(jabMask)
);

// File: tb/evt_irq_regs_tb.sv
`timescale 1ns/1ps
module evt_irq_regs_tb;
  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        stopCtl = 1'b0;
  logic        tpMode = 1'b1;
  logic        legacyStyle = 1'b0;
  logic        irqEnable = 1'b0;
  logic        txStartEvt = 1'b0;
  logic        jabberEvt = 1'b0;
  logic        ringLoad = 1'b0;
  logic [3:0]  ringTxCode = 4'h0;
  logic [3:0]  ringRxCode = 4'h0;
  logic [1:0]  regAddr = 2'd0;
  logic [3:0]  regWdata = 4'h0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regRdata;
  logic        irqReq;

  int vectors = 0;
  int errs = 0;
  logic [15:0] rd;

  always #2 clk = ~clk;

  evt_irq_regs u_dut (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stopCtl(stopCtl),
    .tpMode(tpMode), .legacyStyle(legacyStyle), .irqEnable(irqEnable),
    .txStartEvt(txStartEvt), .jabberEvt(jabberEvt), .ringLoad(ringLoad),
    .ringTxCode(ringTxCode), .ringRxCode(ringRxCode), .regAddr(regAddr),
    .regWdata(regWdata), .regWr(regWr), .regRd(regRd),
    .regRdata(regRdata), .irqReq(irqReq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [3:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    tick();
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    regAddr = a; regRd = 1'b1;
    tick();
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic pulseSoft();
    softRst = 1'b1; tick(); softRst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    hardRstN = 1'b1;
    tick();
    // R1 hard reset state
    readReg(2'd0, rd);
    check("R1 hard reset word", rd, 16'h0005);
    check("R1 hard reset irq", {15'd0, irqReq}, 16'd0);

    // Sweep: enable x masks x events (R2 R3 R7 R8 R12)
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 4; m++) begin
        for (int ev = 0; ev < 4; ev++) begin
          pulseSoft();
          irqEnable = en[0];
          writeReg(2'd0, {1'b0, m[1], 1'b0, m[0]});
          txStartEvt = ev[1]; jabberEvt = ev[0];
          tick();
          txStartEvt = 1'b0; jabberEvt = 1'b0;
          readReg(2'd0, rd);
          check("R2/R3/R7/R12 status word", rd, {12'd0, ev[1], m[1], ev[0], m[0]});
          check("R8 irq level", {15'd0, irqReq},
                {15'd0, en[0] & ((ev[1] & ~m[1]) | (ev[0] & ~m[0]))});
        end
      end
    end
    irqEnable = 1'b0;

    // R1 soft reset state
    writeReg(2'd0, 4'h0);
    txStartEvt = 1'b1; tick(); txStartEvt = 1'b0;
    pulseSoft();
    readReg(2'd0, rd);
    check("R1 soft reset word", rd, 16'h0005);

    // R3 jabber ignored outside 10BASE-T mode
    tpMode = 1'b0; jabberEvt = 1'b1; tick(); jabberEvt = 1'b0; tpMode = 1'b1;
    readReg(2'd0, rd);
    check("R3 jabber without tp mode", rd, 16'h0005);

    // R9 legacy style hides jabber
    legacyStyle = 1'b1; jabberEvt = 1'b1; tick(); jabberEvt = 1'b0;
    readReg(2'd0, rd);
    check("R9 legacy word", rd, 16'h0004);
    legacyStyle = 1'b0;
    readReg(2'd0, rd);
    check("R9 mask returns, jabber still clear", rd, 16'h0005);

    // R4 write-one clear
    txStartEvt = 1'b1; jabberEvt = 1'b1; tick(); txStartEvt = 1'b0; jabberEvt = 1'b0;
    writeReg(2'd0, 4'h5);
    readReg(2'd0, rd);
    check("R4 zero writes keep status", rd, 16'h000F);
    writeReg(2'd0, 4'hD);
    readReg(2'd0, rd);
    check("R4 clear transmit start only", rd, 16'h0007);
    writeReg(2'd0, 4'h7);
    readReg(2'd0, rd);
    check("R4 clear jabber", rd, 16'h0005);

    // R5 set beats clear
    txStartEvt = 1'b1; tick(); txStartEvt = 1'b0;
    txStartEvt = 1'b1; writeReg(2'd0, 4'hD); txStartEvt = 1'b0;
    readReg(2'd0, rd);
    check("R5 set wins over clear", rd, 16'h000D);

    // R6 STOP clears status, blocks set, keeps masks
    writeReg(2'd0, 4'h1);
    txStartEvt = 1'b1; jabberEvt = 1'b1; tick();
    stopCtl = 1'b1; tick();
    txStartEvt = 1'b0; jabberEvt = 1'b0;
    readReg(2'd0, rd);
    check("R6 stop clears, masks kept", rd, 16'h0001);
    irqEnable = 1'b1;
    tick();
    check("R6 no irq while stopped", {15'd0, irqReq}, 16'd0);
    irqEnable = 1'b0;

    // R10 ring sweep while stopped
    for (int t = 0; t < 16; t++) begin
      for (int r = 0; r < 16; r++) begin
        ringTxCode = t[3:0]; ringRxCode = r[3:0]; ringLoad = 1'b1;
        tick();
        ringLoad = 1'b0;
        readReg(2'd1, rd);
        check("R10 ring word", rd, {t[3:0], r[3:0], 8'd0});
      end
    end
    ringTxCode = 4'hA; ringRxCode = 4'h5; ringLoad = 1'b1; tick(); ringLoad = 1'b0;
    ringTxCode = 4'h0; ringRxCode = 4'h0;

    // R11 writes and resets leave ring codes
    writeReg(2'd1, 4'hF);
    pulseSoft();
    hardRstN = 1'b0; tick(); hardRstN = 1'b1; tick();
    readReg(2'd1, rd);
    check("R11 ring kept", rd, 16'hA500);

    // R10 hidden when running
    stopCtl = 1'b0;
    readReg(2'd1, rd);
    check("R10 ring hidden", rd, 16'h0000);
    stopCtl = 1'b1;
    readReg(2'd1, rd);
    check("R11 ring kept across stop", rd, 16'hA500);
    stopCtl = 1'b0;

    // R12 unmapped address and hold
    readReg(2'd2, rd);
    check("R12 unmapped address", rd, 16'h0000);
    readReg(2'd0, rd);
    tick();
    check("R12 hold without read", regRdata, 16'h0005);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule